// File: doc/BRIEF.md
# Arithmetic and Flag Unit

This block is the integer add/subtract datapath of a processor execution stage, together with the logic that produces its status flags. Each clock cycle it takes an operation code, a byte/word width select, a destination operand, a source operand and the current flag word. One cycle later it presents the result, a write strobe for the destination register, and the flag word that should replace the current one.

Nine operations are supported: add, add with carry, subtract, subtract with borrow, compare, bitwise test, increment, decrement and negate. All the arithmetic operations share one adder/subtractor. Operand steering chooses the adder's inputs for each operation. Per-operation rules then decide what each flag takes.

Compare and test update the flags but never write the destination. Increment and decrement leave the carry flag alone. Negate derives its carry from whether the operand was nonzero. The width select masks the operands and picks bit 7 or bit 15 as the sign and carry position.

Top module: `alu_flag_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next outputs are `result_out` = 0, `dst_we` = 0 and `flags_out` = 0.
- R2: Outputs are registered. The result, write strobe and flags for the inputs present at one rising edge appear after that edge and hold until the next edge, so operations may be issued back to back every cycle.
- R3: Opcode 0 (add) and opcode 1 (add with carry) produce `dst + src` (+ `flags_in` bit 0 for opcode 1) at the selected width. The flag word's bit 0 (CF) takes the carry out of the top bit of that width.
- R4: Opcode 2 (subtract), opcode 3 (subtract with borrow) and opcode 4 (compare) produce `dst - src` (- CF for opcode 3). CF takes the borrow out of the top bit of the selected width.
- R5: For arithmetic operations, flag bit 2 (AF) is the carry or borrow between bit 3 and bit 4. For increment and decrement, AF is set when bit 4 of the operand and bit 4 of the result differ.
- R6: For add, subtract and compare, flag bit 5 (OF) is set on a signed overflow at the selected width.
- R7: For every defined opcode, flag bit 1 (PF) is set when the low 8 bits of the result hold an even number of ones. Flag bit 4 (SF) equals the top bit of the result at the selected width. Flag bit 3 (ZF) is set when the result is zero.
- R8: Opcode 5 (test) outputs `dst & src`, clears CF and OF, and sets SF, ZF and PF from that value. AF is passed through from `flags_in` bit 2.
- R9: Opcode 6 (increment) and opcode 7 (decrement) add or subtract one and ignore `src`. CF is copied from `flags_in`. For increment, OF is set when the result is the sign-bit-only value (0x80 or 0x8000). For decrement, OF is set when the operand was that value.
- R10: Opcode 8 (negate) outputs `0 - dst` and ignores `src`. CF is set exactly when the masked operand is nonzero. OF is set when the result is the sign-bit-only value.
- R11: `dst_we` is 1 for opcodes 0-3 and 6-8, and 0 for compare (4) and test (5).
- R12: With `wide_sel` = 0 (byte), bits 15:8 of both operands are ignored and bits 15:8 of the result are zero. With `wide_sel` = 1 (word), all 16 bits are used.
- R13: Opcodes 9 to 15 give `result_out` = 0 and `dst_we` = 0, and `flags_out` equals `flags_in` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 4 | Operation select |
| wide_sel | input | 1 | 0 = byte operation, 1 = word operation |
| dst_in | input | 16 | Destination (first) operand |
| src_in | input | 16 | Source (second) operand |
| flags_in | input | 6 | Current flags {OF,SF,ZF,AF,PF,CF}, CF in bit 0 |
| result_out | output | 16 | Registered result |
| dst_we | output | 1 | Registered destination write strobe |
| flags_out | output | 6 | Registered next flags, same layout as flags_in |

## Verification
Two effects can land in the same cycle: the full flag update of a subtraction and the suppression of the destination write, as happens when a compare of equal operands sets ZF and PF while `dst_we` stays low. A second collision is the incoming carry together with byte masking. A byte add with carry is given operands whose upper bytes are nonzero, so the carry-in ripples out of bit 7. The check expects CF to come from bit 7 rather than bit 15 and the result to be zero. Each case is judged against a hand-computed expected result, write strobe and flag word, sampled on the falling edge after the capturing clock edge.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W   = 16;
  localparam int NARROW_W = 8;
  localparam int PAR_W    = 8;
  localparam int OP_W     = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_TEST = 4'd5,
    OP_INC  = 4'd6,
    OP_DEC  = 4'd7,
    OP_NEG  = 4'd8
  } alu_op_e;

  // Bit 0 is the carry flag; bit 5 is overflow.
  typedef struct packed {
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
    logic cf;
  } flags_t;
endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
  import alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic              wide,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] src,
  input  logic              cf_in,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] y,
  output logic              cin,
  output logic              sub_mode
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] dm, sm;

  always_comb begin
    mask = wide ? {DATA_W{1'b1}} : NARROW_MASK;
    dm   = dst & mask;
    sm   = src & mask;
    x        = dm;
    y        = sm;
    cin      = 1'b0;
    sub_mode = 1'b0;
    case (op)
      OP_ADD:  ;
      OP_ADC:  cin = cf_in;
      OP_SUB,
      OP_CMP:  sub_mode = 1'b1;
      OP_SBB:  begin sub_mode = 1'b1; cin = cf_in; end
      OP_INC:  y = ONE;
      OP_DEC:  begin y = ONE; sub_mode = 1'b1; end
      OP_NEG:  begin x = '0; y = dm; sub_mode = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              cin,
  input  logic              sub_mode,
  output logic [DATA_W:0]   full
);
  localparam int EXT_W = DATA_W + 1;

  logic [EXT_W-1:0] xe, ye, ce;

  always_comb begin
    xe = {1'b0, x};
    ye = {1'b0, y};
    ce = {{DATA_W{1'b0}}, cin};
    full = sub_mode ? (xe - ye - ce) : (xe + ye + ce);
  end
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [OP_W-1:0]   op,
  input  logic              wide,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic [DATA_W:0]   full,
  input  flags_t            fin,
  output logic [DATA_W-1:0] result,
  output logic              we,
  output flags_t            fnx
);
  localparam logic [DATA_W-1:0] SGN_WIDE = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] SGN_NARROW =
    {{(DATA_W-NARROW_W){1'b0}}, 1'b1, {(NARROW_W-1){1'b0}}};

  logic [DATA_W-1:0] r_arith, r;
  logic [DATA_W-1:0] sgn_only;
  logic carry, xt, yt, rt, af_arith, ov_add, ov_sub;

  always_comb begin
    sgn_only = wide ? SGN_WIDE : SGN_NARROW;
    r_arith  = full[DATA_W-1:0] & mask;
    carry    = wide ? full[DATA_W] : full[NARROW_W];
    r        = (op == OP_TEST) ? (x & y) : r_arith;
    xt       = wide ? x[DATA_W-1] : x[NARROW_W-1];
    yt       = wide ? y[DATA_W-1] : y[NARROW_W-1];
    rt       = wide ? r[DATA_W-1] : r[NARROW_W-1];
    af_arith = x[4] ^ y[4] ^ r[4];
    ov_add   = (xt == yt) && (rt != xt);
    ov_sub   = (xt != yt) && (rt != xt);

    fnx    = fin;
    we     = 1'b0;
    result = r;
    fnx.pf = ~^r[PAR_W-1:0];
    fnx.sf = rt;
    fnx.zf = (r == '0);
    case (op)
      OP_ADD, OP_ADC: begin
        we = 1'b1; fnx.cf = carry; fnx.af = af_arith; fnx.of = ov_add;
      end
      OP_SUB, OP_SBB: begin
        we = 1'b1; fnx.cf = carry; fnx.af = af_arith; fnx.of = ov_sub;
      end
      OP_CMP: begin
        fnx.cf = carry; fnx.af = af_arith; fnx.of = ov_sub;
      end
      OP_TEST: begin
        fnx.cf = 1'b0; fnx.of = 1'b0;
      end
      OP_INC: begin
        we = 1'b1; fnx.af = x[4] ^ r[4]; fnx.of = (r == sgn_only);
      end
      OP_DEC: begin
        we = 1'b1; fnx.af = x[4] ^ r[4]; fnx.of = (x == sgn_only);
      end
      OP_NEG: begin
        we = 1'b1; fnx.cf = (y != '0); fnx.af = af_arith;
        fnx.of = (r == sgn_only);
      end
      default: begin
        result = '0;
        fnx    = fin;
      end
    endcase
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op_code,
  input  logic              wide_sel,
  input  logic [DATA_W-1:0] dst_in,
  input  logic [DATA_W-1:0] src_in,
  input  logic [5:0]        flags_in,
  output logic [DATA_W-1:0] result_out,
  output logic              dst_we,
  output logic [5:0]        flags_out
);
  logic [DATA_W-1:0] mask, x, y, res_nx;
  logic [DATA_W:0]   full;
  logic              cin, sub_mode, we_nx;
  flags_t            fin, fnx;

  assign fin = flags_t'(flags_in);

  alu_opnd_sel #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_sel (
    .op(op_code), .wide(wide_sel), .dst(dst_in), .src(src_in),
    .cf_in(fin.cf), .mask(mask), .x(x), .y(y), .cin(cin),
    .sub_mode(sub_mode)
  );

  alu_addsub #(.DATA_W(DATA_W)) i_add (
    .x(x), .y(y), .cin(cin), .sub_mode(sub_mode), .full(full)
  );

  alu_flag_gen #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_flg (
    .op(op_code), .wide(wide_sel), .mask(mask), .x(x), .y(y),
    .full(full), .fin(fin), .result(res_nx), .we(we_nx), .fnx(fnx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result_out <= '0;
      dst_we     <= 1'b0;
      flags_out  <= '0;
    end else begin
      result_out <= res_nx;
      dst_we     <= we_nx;
      flags_out  <= fnx;
    end
  end
endmodule

// File: rtl/alu_flag_unit_chk.sv
module alu_flag_unit_chk
  import alu_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NARROW_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        op_code,
  input logic              wide_sel,
  input logic [DATA_W-1:0] dst_in,
  input logic [DATA_W-1:0] src_in,
  input logic [5:0]        flags_in,
  input logic [DATA_W-1:0] result_out,
  input logic              dst_we,
  input logic [5:0]        flags_out
);
  logic              armed;
  logic [3:0]        p_op;
  logic              p_wide;
  logic [DATA_W-1:0] p_dst, p_src, p_mask;
  logic [5:0]        p_flags;

  always_ff @(posedge clk) begin
    armed   <= !rst;
    p_op    <= op_code;
    p_wide  <= wide_sel;
    p_dst   <= dst_in;
    p_src   <= src_in;
    p_flags <= flags_in;
  end

  assign p_mask = p_wide ? {DATA_W{1'b1}}
                         : {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (result_out == '0 && !dst_we && flags_out == '0));

  assert_add_value_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && p_op == OP_ADD) |-> result_out == ((p_dst + p_src) & p_mask));

  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (armed && p_op <= 4'd8) |-> flags_out[3] == (result_out == '0));

  assert_test_flags_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && p_op == OP_TEST) |->
      (!flags_out[0] && !flags_out[5] && flags_out[2] == p_flags[2]));

  assert_carry_held_R9: assert property (@(posedge clk) disable iff (rst)
    (armed && (p_op == OP_INC || p_op == OP_DEC)) |-> flags_out[0] == p_flags[0]);

  assert_neg_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && p_op == OP_NEG) |-> flags_out[0] == ((p_dst & p_mask) != '0));

  assert_no_write_R11: assert property (@(posedge clk) disable iff (rst)
    (armed && (p_op == OP_CMP || p_op == OP_TEST)) |-> !dst_we);

  assert_narrow_upper_R12: assert property (@(posedge clk) disable iff (rst)
    (armed && !p_wide) |-> result_out[DATA_W-1:NARROW_W] == '0);

  assert_unknown_op_R13: assert property (@(posedge clk) disable iff (rst)
    (armed && p_op > 4'd8) |-> (!dst_we && flags_out == p_flags));
endmodule

bind alu_flag_unit alu_flag_unit_chk #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) i_chk (
  .clk(clk), .rst(rst), .op_code(op_code), .wide_sel(wide_sel),
  .dst_in(dst_in), .src_in(src_in), .flags_in(flags_in),
  .result_out(result_out), .dst_we(dst_we), .flags_out(flags_out)
);

// File: tb/test_alu_flag_unit.sv
module test_alu_flag_unit;
  import alu_pkg::*;

  typedef struct packed {
    logic [3:0]  op;
    logic        wide;
    logic [15:0] a;
    logic [15:0] b;
    logic [5:0]  fin;
    logic [15:0] res;
    logic        we;
    logic [5:0]  fout;
  } vec_t;

  localparam int NVEC = 20;
  // flags written {OF,SF,ZF,AF,PF,CF}
  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 1'b0, 16'h007F, 16'h0001, 6'b000000, 16'h0080, 1'b1, 6'b110100}, // R3 R5 R6 signed overflow
    '{4'd0, 1'b0, 16'h00FF, 16'h0001, 6'b000000, 16'h0000, 1'b1, 6'b001111}, // R3 R7 carry out bit 7
    '{4'd1, 1'b0, 16'h0010, 16'h0020, 6'b000001, 16'h0031, 1'b1, 6'b000000}, // R3 carry folded in
    '{4'd2, 1'b0, 16'h0000, 16'h0001, 6'b000000, 16'h00FF, 1'b1, 6'b010111}, // R4 R5 borrow
    '{4'd3, 1'b1, 16'h8000, 16'h0000, 6'b000001, 16'h7FFF, 1'b1, 6'b100110}, // R4 R6 borrow folded, overflow
    '{4'd4, 1'b0, 16'h0005, 16'h0005, 6'b000000, 16'h0000, 1'b0, 6'b001010}, // R4 R11 compare no write
    '{4'd5, 1'b1, 16'hF0F0, 16'h0FF0, 6'b111111, 16'h00F0, 1'b0, 6'b000110}, // R8 R11 AF passed through
    '{4'd5, 1'b0, 16'h0081, 16'h0080, 6'b000000, 16'h0080, 1'b0, 6'b010000}, // R8 R7 SF from AND
    '{4'd6, 1'b0, 16'h007F, 16'h0055, 6'b000001, 16'h0080, 1'b1, 6'b110101}, // R9 R5 inc OF, CF kept
    '{4'd6, 1'b1, 16'hFFFF, 16'h0055, 6'b000000, 16'h0000, 1'b1, 6'b001110}, // R9 inc wrap, CF kept 0
    '{4'd7, 1'b0, 16'h0080, 16'h0055, 6'b000000, 16'h007F, 1'b1, 6'b100100}, // R9 R5 dec OF
    '{4'd7, 1'b1, 16'h0001, 16'h0055, 6'b000001, 16'h0000, 1'b1, 6'b001011}, // R9 dec to zero, CF kept 1
    '{4'd8, 1'b0, 16'h0000, 16'h0055, 6'b000000, 16'h0000, 1'b1, 6'b001010}, // R10 zero operand: CF 0
    '{4'd8, 1'b0, 16'h0080, 16'h0055, 6'b000000, 16'h0080, 1'b1, 6'b110001}, // R10 sign-only result
    '{4'd8, 1'b1, 16'h0001, 16'h0055, 6'b000000, 16'hFFFF, 1'b1, 6'b010111}, // R10 R5 word negate
    '{4'd0, 1'b1, 16'h00FF, 16'h0001, 6'b000000, 16'h0100, 1'b1, 6'b000110}, // R12 word: no carry at bit 7
    '{4'd0, 1'b0, 16'hAB12, 16'h3400, 6'b000000, 16'h0012, 1'b1, 6'b000010}, // R12 upper bytes ignored
    '{4'hF, 1'b0, 16'h1234, 16'h5678, 6'b101010, 16'h0000, 1'b0, 6'b101010}, // R13 undefined opcode
    '{4'd2, 1'b1, 16'h1000, 16'h0001, 6'b000000, 16'h0FFF, 1'b1, 6'b000110}, // R4 R5 word borrow at nibble
    '{4'd1, 1'b0, 16'h01FF, 16'h0100, 6'b000001, 16'h0000, 1'b1, 6'b001111}  // R3 R12 carry-in out of bit 7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_code = '0;
  logic        wide_sel = 1'b0;
  logic [15:0] dst_in = '0;
  logic [15:0] src_in = '0;
  logic [5:0]  flags_in = '0;
  logic [15:0] result_out;
  logic        dst_we;
  logic [5:0]  flags_out;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  alu_flag_unit i_alu_flag_unit (
    .clk(clk), .rst(rst), .op_code(op_code), .wide_sel(wide_sel),
    .dst_in(dst_in), .src_in(src_in), .flags_in(flags_in),
    .result_out(result_out), .dst_we(dst_we), .flags_out(flags_out)
  );

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0, 4'd1:       return "R3";
      4'd2, 4'd3, 4'd4: return "R4";
      4'd5:             return "R8";
      4'd6, 4'd7:       return "R9";
      4'd8:             return "R10";
      default:          return "R13";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic w, input logic [15:0] a,
                       input logic [15:0] b, input logic [5:0] f);
    op_code = op; wide_sel = w; dst_in = a; src_in = b; flags_in = f;
  endtask

  task automatic check(input string tag, input logic [15:0] er, input logic ew,
                       input logic [5:0] ef);
    checks++;
    if (result_out !== er || dst_we !== ew || flags_out !== ef) begin
      errors++;
      $display("FAIL %s: result=%h we=%b flags=%b, expected result=%h we=%b flags=%b",
               tag, result_out, dst_we, flags_out, er, ew, ef);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", 16'h0000, 1'b0, 6'b000000);
    rst = 1'b0;

    foreach (VECS[i]) begin
      drive(VECS[i].op, VECS[i].wide, VECS[i].a, VECS[i].b, VECS[i].fin);
      @(negedge clk);
      check(tag_of(VECS[i].op), VECS[i].res, VECS[i].we, VECS[i].fout);
    end

    // R2: back-to-back issue, each result one cycle after its inputs
    drive(4'd0, 1'b0, 16'h0001, 16'h0001, 6'b000000);
    @(negedge clk);
    drive(4'd2, 1'b0, 16'h0003, 16'h0005, 6'b000000);
    check("R2 first of pair", 16'h0002, 1'b1, 6'b000000);
    @(negedge clk);
    check("R2 second of pair", 16'h00FE, 1'b1, 6'b010101);

    // R1: reset asserted with a live operation clears the outputs
    rst = 1'b1;
    drive(4'd0, 1'b0, 16'h007F, 16'h0001, 6'b111111);
    @(negedge clk);
    check("R1 reset mid-stream", 16'h0000, 1'b0, 6'b000000);
    rst = 1'b0;
    @(negedge clk);
    check("R6 after reset release", 16'h0080, 1'b1, 6'b110100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule